// File: doc/BRIEF.md
# Alternative-Route Configuration Loader

This block brings a routed fabric up from a single configuration stream that is the same for every chip. The stream lists each net's candidate paths in order: the primary path first, then the fallbacks. The loader writes the words of one candidate into the fabric, one word per strobe. It then asks an external path tester to check that route. If the tester reports a good path, the loader jumps past the net's unused candidates to the next net's record. If the tester reports a bad path, the loader writes the next candidate of the same net.

Defects are therefore handled while the configuration loads, and no per-chip defect map is needed. Each net record opens with a header that gives the candidate count, followed by the length of every candidate. This lets the loader compute where the next record begins and jump there with a single address update. If every candidate of a net fails, or a record header is malformed, the loader stops, raises an error and reports which net it was working on. After the last net it reports completion.

The stream is read through a synchronous read port with one cycle of latency: data for an address issued with `rd_en` appears on `rd_data` in the following cycle.

Top module: `rl_route_loader`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `error`, `err_net`, `rd_en`, `cfg_we` and `test_start` are all low or zero.
- R2: Stream layout, which the loader relies on:
  - Word 0 carries the net count in bits [7:0].
  - Each net record starts with a header word whose bits [3:0] give the candidate count.
  - The header is followed by one length word per candidate, with the length in bits [7:0].
  - The candidate bodies follow, stored back to back in candidate order.
- R3: A candidate's body words appear on `cfg_data` with `cfg_we` high, one word per strobe, in stream order and unchanged.
- R4: `test_start` is a one-cycle pulse. It comes after the last write of a candidate, and there is no write or read while the loader waits for the test result.
- R5: A passing result (`test_done` with `test_pass` high) makes the loader skip the net's remaining candidates. The next net's header is read from the word just after that net's last candidate body.
- R6: A failing result makes the loader write and test the next candidate of the same net.
- R7: When the last candidate of a net fails, the loader:
  - raises `error`;
  - sets `err_net` to the net's zero-based index;
  - issues no further reads or writes until a new start.
- R8: A candidate count of 0, or one above the table depth (8), raises `error` with `err_net` set to that net's index.
- R9: `done` rises after the last net has passed. A net count of 0 gives `done` with no writes and no tests. `done` and `error` are never high together.
- R10: `start` while the loader is busy is ignored. `start` after `done` or `error` reloads the stream from word 0.
- R11: A `test_done` that arrives while no test is pending has no effect on the writes or the outcome.
- R12: A candidate of length 0 is tested at once, with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin loading from stream word 0 |
| rd_en | output | 1 | Stream read request |
| rd_addr | output | 10 | Stream word address |
| rd_data | input | 16 | Stream word, valid one cycle after `rd_en` |
| cfg_we | output | 1 | Configuration write strobe |
| cfg_data | output | 16 | Configuration word |
| test_start | output | 1 | Path test request pulse |
| test_done | input | 1 | Path test finished |
| test_pass | input | 1 | Path test result, qualified by `test_done` |
| busy | output | 1 | Loading in progress |
| done | output | 1 | All nets routed |
| error | output | 1 | Loading stopped on a net with no working path or a bad header |
| err_net | output | 8 | Index of the failing net |

## Verification
The bench builds the loader with its default parameters: 16-bit words, a 10-bit stream address, an 8-entry length table and 8-bit net and length fields. With these values, a candidate count of 9 exceeds the table while still fitting in the 4-bit count field, so the overflow path can be reached. The scenarios cover:
- a zero-length candidate;
- three-way fallback within one net;
- a last-net exhaustion, and an exhaustion on a later net;
- a responder latency of zero as well as a longer one.

// File: rtl/rl_pkg.sv
package rl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_CONFIG,
    ST_TEST,
    ST_SKIP,
    ST_NEXT,
    ST_DONE,
    ST_ERROR
  } rl_state_e;

  typedef enum logic [1:0] {
    PH_NETS,
    PH_ALTS,
    PH_LENS
  } rl_phase_e;
endpackage

// File: rtl/rl_len_table.sv
// Small length table for the candidates of the current net.
// Asynchronous read keeps it in distributed RAM.
module rl_len_table #(
  parameter int LEN_W = 8,
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [LEN_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [LEN_W-1:0] rdata
);
  logic [LEN_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rl_cfg_out.sv
// Output register stage for configuration writes.
module rl_cfg_out #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              cfg_we_o,
  output logic [DATA_W-1:0] cfg_data_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_we_o   <= 1'b0;
      cfg_data_o <= '0;
    end else begin
      cfg_we_o <= vld_i;
      if (vld_i) cfg_data_o <= data_i;
    end
  end

  // R3: a strobed word is the word that was valid one cycle earlier
  a_r3_data_follows: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> (cfg_we_o && cfg_data_o == $past(data_i)));
endmodule

// File: rtl/rl_seq.sv
module rl_seq
  import rl_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int NET_W    = 8,
  parameter int ALT_W    = 4,
  parameter int LEN_W    = 8,
  parameter int MAX_ALTS = 8,
  parameter int IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [NET_W-1:0]  nets_fld,
  input  logic [ALT_W-1:0]  alts_fld,
  input  logic [LEN_W-1:0]  len_fld,
  input  logic              test_done,
  input  logic              test_pass,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              word_vld,
  output logic              test_start,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [NET_W-1:0]  err_net,
  output logic              tbl_we,
  output logic [IDX_W-1:0]  tbl_waddr,
  output logic [LEN_W-1:0]  tbl_wdata,
  output logic [IDX_W-1:0]  tbl_raddr,
  input  logic [LEN_W-1:0]  tbl_rdata
);
  localparam logic [ALT_W-1:0] MAX_A = ALT_W'(MAX_ALTS);

  rl_state_e         state;
  rl_phase_e         phase;
  logic              vld;
  logic [ADDR_W-1:0] cur;
  logic [ADDR_W-1:0] total;
  logic [ADDR_W-1:0] next_net;
  logic [NET_W-1:0]  net_total;
  logic [NET_W-1:0]  net_idx;
  logic [ALT_W-1:0]  alt_cnt;
  logic [ALT_W-1:0]  alt_idx;
  logic [ALT_W-1:0]  len_idx;
  logic [LEN_W-1:0]  iss;

  assign word_vld  = vld && (state == ST_CONFIG);
  assign tbl_we    = vld && (state == ST_HDR) && (phase == PH_LENS);
  assign tbl_waddr = len_idx[IDX_W-1:0];
  assign tbl_wdata = len_fld;
  assign tbl_raddr = alt_idx[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      phase      <= PH_NETS;
      vld        <= 1'b0;
      rd_en      <= 1'b0;
      rd_addr    <= '0;
      cur        <= '0;
      total      <= '0;
      next_net   <= '0;
      net_total  <= '0;
      net_idx    <= '0;
      alt_cnt    <= '0;
      alt_idx    <= '0;
      len_idx    <= '0;
      iss        <= '0;
      test_start <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      error      <= 1'b0;
      err_net    <= '0;
    end else begin
      vld        <= rd_en;
      rd_en      <= 1'b0;
      test_start <= 1'b0;
      case (state)
        ST_IDLE, ST_DONE, ST_ERROR: begin
          if (start) begin
            rd_en   <= 1'b1;
            rd_addr <= '0;
            cur     <= ADDR_W'(1);
            phase   <= PH_NETS;
            state   <= ST_HDR;
            busy    <= 1'b1;
            done    <= 1'b0;
            error   <= 1'b0;
            err_net <= '0;
          end
        end
        ST_HDR: begin
          if (vld) begin
            case (phase)
              PH_NETS: begin
                net_total <= nets_fld;
                net_idx   <= '0;
                if (nets_fld == '0) begin
                  state <= ST_DONE;
                  done  <= 1'b1;
                  busy  <= 1'b0;
                end else begin
                  rd_en   <= 1'b1;
                  rd_addr <= cur;
                  cur     <= cur + 1'b1;
                  phase   <= PH_ALTS;
                end
              end
              PH_ALTS: begin
                alt_cnt <= alts_fld;
                if (alts_fld == '0 || alts_fld > MAX_A) begin
                  state   <= ST_ERROR;
                  error   <= 1'b1;
                  err_net <= net_idx;
                  busy    <= 1'b0;
                end else begin
                  rd_en   <= 1'b1;
                  rd_addr <= cur;
                  cur     <= cur + 1'b1;
                  len_idx <= '0;
                  total   <= '0;
                  phase   <= PH_LENS;
                end
              end
              default: begin
                total <= total + ADDR_W'(len_fld);
                if (len_idx == alt_cnt - 1'b1) begin
                  next_net <= cur + total + ADDR_W'(len_fld);
                  alt_idx  <= '0;
                  iss      <= '0;
                  state    <= ST_CONFIG;
                end else begin
                  rd_en   <= 1'b1;
                  rd_addr <= cur;
                  cur     <= cur + 1'b1;
                  len_idx <= len_idx + 1'b1;
                end
              end
            endcase
          end
        end
        ST_CONFIG: begin
          if (iss != tbl_rdata) begin
            rd_en   <= 1'b1;
            rd_addr <= cur;
            cur     <= cur + 1'b1;
            iss     <= iss + 1'b1;
          end else if (!rd_en && !vld) begin
            test_start <= 1'b1;
            state      <= ST_TEST;
          end
        end
        ST_TEST: begin
          if (test_done) begin
            if (test_pass) begin
              state <= ST_SKIP;
            end else if (alt_idx == alt_cnt - 1'b1) begin
              state   <= ST_ERROR;
              error   <= 1'b1;
              err_net <= net_idx;
              busy    <= 1'b0;
            end else begin
              alt_idx <= alt_idx + 1'b1;
              iss     <= '0;
              state   <= ST_CONFIG;
            end
          end
        end
        ST_SKIP: begin
          cur     <= next_net;
          net_idx <= net_idx + 1'b1;
          state   <= ST_NEXT;
        end
        default: begin
          if (net_idx == net_total) begin
            state <= ST_DONE;
            done  <= 1'b1;
            busy  <= 1'b0;
          end else begin
            rd_en   <= 1'b1;
            rd_addr <= cur;
            cur     <= cur + 1'b1;
            phase   <= PH_ALTS;
            state   <= ST_HDR;
          end
        end
      endcase
    end
  end

  // R4: the test request is a single-cycle pulse
  a_r4_start_pulse: assert property (@(posedge clk) disable iff (rst)
    test_start |=> !test_start);

  // R4: no stream reads while a test result is pending
  a_r4_quiet_in_test: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TEST) |-> !rd_en);

  // R5: a skip only follows a passing result
  a_r5_skip_on_pass: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> $past(test_done && test_pass));

  // R7: error holds, with no reads, until a new start
  a_r7_error_hold: assert property (@(posedge clk) disable iff (rst)
    (error && !start) |=> (error && !rd_en));

  // R9: completion and error are exclusive
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && error));
endmodule

// File: rtl/rl_route_loader.sv
module rl_route_loader #(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 10,
  parameter int NET_W    = 8,
  parameter int ALT_W    = 4,
  parameter int LEN_W    = 8,
  parameter int MAX_ALTS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              cfg_we,
  output logic [DATA_W-1:0] cfg_data,
  output logic              test_start,
  input  logic              test_done,
  input  logic              test_pass,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [NET_W-1:0]  err_net
);
  localparam int IDX_W = (MAX_ALTS > 1) ? $clog2(MAX_ALTS) : 1;

  logic              word_vld;
  logic              tbl_we;
  logic [IDX_W-1:0]  tbl_waddr;
  logic [IDX_W-1:0]  tbl_raddr;
  logic [LEN_W-1:0]  tbl_wdata;
  logic [LEN_W-1:0]  tbl_rdata;

  rl_seq #(
    .ADDR_W(ADDR_W), .NET_W(NET_W), .ALT_W(ALT_W),
    .LEN_W(LEN_W), .MAX_ALTS(MAX_ALTS), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .nets_fld(rd_data[NET_W-1:0]),
    .alts_fld(rd_data[ALT_W-1:0]),
    .len_fld(rd_data[LEN_W-1:0]),
    .test_done(test_done), .test_pass(test_pass),
    .rd_en(rd_en), .rd_addr(rd_addr), .word_vld(word_vld),
    .test_start(test_start), .busy(busy), .done(done),
    .error(error), .err_net(err_net),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .tbl_raddr(tbl_raddr), .tbl_rdata(tbl_rdata)
  );

  rl_len_table #(.LEN_W(LEN_W), .DEPTH(MAX_ALTS), .IDX_W(IDX_W)) u_tbl (
    .clk(clk), .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
    .raddr(tbl_raddr), .rdata(tbl_rdata)
  );

  rl_cfg_out #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .vld_i(word_vld), .data_i(rd_data),
    .cfg_we_o(cfg_we), .cfg_data_o(cfg_data)
  );

  // R4: a test request never coincides with a write
  a_r4_no_write_at_test: assert property (@(posedge clk) disable iff (rst)
    test_start |-> !cfg_we);

  // R3: writes only happen during a load
  a_r3_write_while_busy: assert property (@(posedge clk) disable iff (rst)
    cfg_we |-> busy);

  // R1: an idle-after-completion loader is not busy
  a_r1_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/test_rl_route_loader.sv
module test_rl_route_loader;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 10;
  localparam int NET_W  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data = '0;
  logic              cfg_we;
  logic [DATA_W-1:0] cfg_data;
  logic              test_start;
  logic              resp_done = 1'b0;
  logic              spur_done = 1'b0;
  logic              test_done;
  logic              test_pass = 1'b0;
  logic              busy, done, error;
  logic [NET_W-1:0]  err_net;

  assign test_done = resp_done | spur_done;

  always #10 clk = ~clk;

  rl_route_loader i_rl_route_loader (
    .clk(clk), .rst(rst), .start(start), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .test_start(test_start), .test_done(test_done), .test_pass(test_pass),
    .busy(busy), .done(done), .error(error), .err_net(err_net)
  );

  logic [DATA_W-1:0] mem [1024];
  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  int checks = 0;
  int errors = 0;
  int wp;
  int uid = 0;
  int resp_lat = 2;
  bit script[$];
  bit pass_q[$];
  int exp_wr[$];
  int exp_tests, tests_seen;
  bit exp_done, exp_err;
  int exp_net;
  string cur_req = "R3";

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic put(input int w);
    mem[wp] = DATA_W'(w);
    wp++;
  endtask

  // header, lengths, then bodies of distinct words
  task automatic add_net(input int hdr, input int lens[$]);
    put(hdr);
    foreach (lens[i]) put(lens[i]);
    foreach (lens[i]) for (int k = 0; k < lens[i]; k++) begin
      put(16'hA000 + uid);
      uid++;
    end
  endtask

  task automatic new_stream(input int nets);
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    wp = 0;
    put(nets);
    script.delete();
  endtask

  // behavioural reference of the load sequence
  function automatic void run_model();
    int ptr, n, a, body, tot, c, ti;
    int lens[$];
    exp_wr.delete();
    exp_tests = 0; exp_done = 0; exp_err = 0; exp_net = 0; ti = 0;
    n = mem[0] & 255;
    ptr = 1;
    for (int net = 0; net < n; net++) begin
      a = mem[ptr] & 15;
      ptr++;
      if (a == 0 || a > 8) begin exp_err = 1; exp_net = net; return; end
      lens.delete();
      tot = 0;
      for (int k = 0; k < a; k++) begin
        lens.push_back(mem[ptr] & 255); tot += mem[ptr] & 255; ptr++;
      end
      body = ptr;
      c = body;
      for (int k = 0; k < a; k++) begin
        bit ok;
        for (int j = 0; j < lens[k]; j++) exp_wr.push_back(int'(mem[c + j]));
        c += lens[k];
        exp_tests++;
        ok = (ti < script.size()) ? script[ti] : 1'b0;
        ti++;
        if (ok) break;
        if (k == a - 1) begin exp_err = 1; exp_net = net; return; end
      end
      ptr = body + tot;
    end
    exp_done = 1;
  endfunction

  // writes compared on every clock against the model
  always @(negedge clk) begin
    if (!rst && cfg_we) begin
      if (exp_wr.size() == 0) begin
        chk(1'b0, cur_req, "unexpected write", int'(cfg_data), -1);
      end else begin
        int e;
        e = exp_wr.pop_front();
        chk(int'(cfg_data) == e, cur_req, "cfg word", int'(cfg_data), e);
      end
    end
    if (!rst && test_start) tests_seen++;
  end

  // path tester responder
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && test_start) begin
        repeat (resp_lat) @(negedge clk);
        test_pass = (pass_q.size() > 0) ? pass_q.pop_front() : 1'b0;
        resp_done = 1'b1;
        @(negedge clk);
        resp_done = 1'b0;
        test_pass = 1'b0;
      end
    end
  end

  task automatic run(input string req, input int lat, input bit disturb);
    int t;
    run_model();
    pass_q = script;
    resp_lat = lat;
    tests_seen = 0;
    cur_req = req;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (disturb) begin
      // R11: stray result while writing; R10: start while busy
      repeat (9) @(negedge clk);
      spur_done = 1'b1; test_pass = 1'b1;
      @(negedge clk);
      spur_done = 1'b0; test_pass = 1'b0;
      repeat (10) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!(done || error) && t < 5000) begin @(negedge clk); t++; end
    repeat (8) @(negedge clk);
    chk(exp_wr.size() == 0, req, "missing writes", exp_wr.size(), 0);
    chk(tests_seen == exp_tests, req, "test count", tests_seen, exp_tests);
    chk(done == exp_done, "R9", "done", int'(done), int'(exp_done));
    chk(error == exp_err, "R7", "error", int'(error), int'(exp_err));
    if (exp_err) chk(int'(err_net) == exp_net, "R7", "err_net", int'(err_net), exp_net);
    chk(!busy, "R9", "busy after end", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !error && !rd_en && !cfg_we && !test_start && err_net == 0,
        "R1", "reset outputs", int'({busy, done, error, rd_en, cfg_we, test_start}), 0);

    // R2 R3 R5 R6 R10 R11: three nets, fallback within the second
    new_stream(3);
    add_net(2, '{3, 2});    script.push_back(1);
    add_net(3, '{2, 4, 1}); script.push_back(0); script.push_back(0); script.push_back(1);
    add_net(1, '{1});       script.push_back(1);
    run("R6", 2, 1'b1);

    // R7: last net exhausts its candidates; R10 restart after done
    new_stream(2);
    add_net(1, '{2});    script.push_back(1);
    add_net(2, '{2, 2}); script.push_back(0); script.push_back(0);
    run("R7", 1, 1'b0);

    // R12: zero-length first candidate fails, second passes; R8 count 0 on net 1
    new_stream(2);
    add_net(2, '{0, 2}); script.push_back(0); script.push_back(1);
    put(0);
    run("R12", 3, 1'b0);

    // R9: empty stream
    new_stream(0);
    run("R9", 1, 1'b0);

    // R8: candidate count above table depth
    new_stream(1);
    put(9);
    run("R8", 1, 1'b0);

    // R5: zero responder latency, single net; R10 restart after error
    new_stream(1);
    add_net(1, '{2}); script.push_back(1);
    run("R5", 0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule